// File: doc/BRIEF.md
# Two-Way Coherent Data Cache Controller

This block is a physically addressed 8-Kbyte data cache with two ways per set. A core issues single-word loads and stores through a request channel. Each store carries a flag that picks its write policy: write-back or write-through. The cache keeps a two-bit coherency state on every line. That state is Invalid, Exclusive or Modified. Loads and stores that hit are served from the internal arrays. A miss picks a victim way. If the victim is Modified, its eight words are written to memory first. Then an external fill engine is asked for the whole new line, and the line arrives as eight sequential 32-bit beats.

The block accepts one request at a time. Once a request is accepted, `req_ready` stays low until the core has taken the response. That includes the whole of any eviction and line fill, so the core is stalled for the duration. Every store also produces a response, and its data field carries no meaning. All data channels use valid/ready. A source holds valid, and the payload with it, until ready is seen high at a clock edge. The cache obeys this rule on its response, memory-write and fill-request channels. On the fill-data channel a beat is taken on any cycle in which `fdat_valid` and `fdat_ready` are both high. `fdat_ready` is high only while the cache is waiting for fill beats.

Top module: `dc_mei_cache`

## Requirements
- R1: After reset every line is Invalid and every set's replacement bit is 0. `req_ready` is high and no other valid output is asserted. A line that was present before a reset misses afterwards.
- R2: The request address is a word address (byte address bits 31:2). Byte address bits 11:5 select one of 128 sets, bits 31:12 form the tag and bits 4:2 pick the word in the 32-byte line. Fill requests carry the byte address of the line base, with bits 4:0 zero.
- R3: A load that hits returns the stored word with no memory write and no fill request.
- R4: A load miss sends one fill request, takes eight beats in word order 0 to 7 into the chosen way, and marks the line Exclusive. It then returns the requested word from the new line.
- R5: A miss replaces an Invalid way if one exists, trying way 0 before way 1. Otherwise it replaces the way named by the set's replacement bit. Every hit and every fill sets that bit to the way not used.
- R6: A write-back store hit updates the word, issues no memory write and leaves the line Modified.
- R7: A write-through store hit updates the word and issues exactly one memory write with the store's address and data. The line state is not changed, so an Exclusive line stays Exclusive and is later evicted without a write-back.
- R8: A write-through store miss issues exactly one memory write, sends no fill request and allocates no line.
- R9: Evicting a Modified victim writes its eight words to memory at line offsets 0, 4, ... 28, in that order, before the fill request is raised. An Exclusive or Invalid victim causes no memory write.
- R10: After a request is accepted, `req_ready` stays low until the response handshake. This covers any eviction and fill in progress.
- R11: While ready is low, `rsp_valid`, `mwr_valid` and `freq_valid` stay asserted, and their data and address are held stable.
- R12: A write-back store miss allocates the line in the same way as a load miss. It then merges the store word, the line becomes Modified, and no memory write is issued for the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wthru | input | 1 | Store policy: 1 = write-through, 0 = write-back |
| req_waddr | input | 30 | Word address (byte address bits 31:2) |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Core takes the response |
| rsp_rdata | output | 32 | Load data |
| mwr_valid | output | 1 | Memory word write valid |
| mwr_ready | input | 1 | Memory accepts the write |
| mwr_addr | output | 32 | Byte address of the word written |
| mwr_data | output | 32 | Word written |
| freq_valid | output | 1 | Line fill request valid |
| freq_ready | input | 1 | Fill engine accepts the request |
| freq_addr | output | 32 | Line base byte address |
| fdat_valid | input | 1 | Fill beat valid |
| fdat_ready | output | 1 | Cache is waiting for fill beats |
| fdat_data | input | 32 | Fill beat word |

## Verification
The bench drives three lines that share one set. This forces victim choice through the empty-way preference and then through the replacement bit. A design that replaced the wrong way would show up as extra fills on later hits. A Modified victim is evicted while memory stalls at random, and the bench checks that all eight writes land at rising offsets before the fill request is taken. A fill requested too early, or beats out of order, would break that check. The data that was written back must also return on a later refill. A write-through hit on an Exclusive line is followed by an eviction of that line. A design that marked it Modified would issue a spurious write-back there. A write-through store miss is followed by a load. That load must still miss and must see the new memory value. Responses are held back for several cycles, and a reset is applied in the middle of the run to catch lines that survive it.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  // Two-bit coherency code kept per line
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_EXC = 2'b01,
    LS_MOD = 2'b10
  } line_st_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LOOK,
    SQ_WTWR,
    SQ_EVICT,
    SQ_FREQ,
    SQ_FILL,
    SQ_RESP
  } seq_st_e;

  localparam int unsigned NWAYS = 2;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store
  import dcache_pkg::*;
#(
  parameter int unsigned SETS  = 128,
  parameter int unsigned TAG_W = 20,
  localparam int unsigned SET_W = $clog2(SETS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SET_W-1:0]              lk_set_i,
  input  logic [TAG_W-1:0]              lk_tag_i,
  output logic [NWAYS-1:0]              hit_o,
  output logic [NWAYS-1:0][1:0]         way_st_o,
  output logic [NWAYS-1:0][TAG_W-1:0]   way_tag_o,
  output logic                          lru_o,
  input  logic                          st_we_i,
  input  logic                          st_way_i,
  input  line_st_e                      st_val_i,
  input  logic                          tag_we_i,
  input  logic                          lru_we_i,
  input  logic                          lru_val_i
);

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    line_st_e         st_q  [SETS];
    logic [TAG_W-1:0] tag_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) st_q[s] <= LS_INV;
      end else if (st_we_i && st_way_i == 1'(w)) begin
        st_q[lk_set_i] <= st_val_i;
      end
    end

    always_ff @(posedge clk) begin
      if (tag_we_i && st_way_i == 1'(w)) tag_q[lk_set_i] <= lk_tag_i;
    end

    assign way_st_o[w]  = st_q[lk_set_i];
    assign way_tag_o[w] = tag_q[lk_set_i];
    assign hit_o[w]     = (st_q[lk_set_i] != LS_INV) && (tag_q[lk_set_i] == lk_tag_i);

    // R1
    st_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      way_st_o[w] != 2'b11);
  end

  logic lru_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) lru_q[s] <= 1'b0;
    end else if (lru_we_i) begin
      lru_q[lk_set_i] <= lru_val_i;
    end
  end

  assign lru_o = lru_q[lk_set_i];

  // R4
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_o));

endmodule

// File: rtl/dc_data_store.sv
module dc_data_store
  import dcache_pkg::*;
#(
  parameter int unsigned SETS       = 128,
  parameter int unsigned LINE_WORDS = 8,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned WORD_W = $clog2(LINE_WORDS),
  localparam int unsigned DEPTH  = SETS * LINE_WORDS
) (
  input  logic              clk,
  input  logic              way_i,
  input  logic [SET_W-1:0]  set_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [NWAYS-1:0][DATA_W-1:0] rd_way;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i && way_i == 1'(w)) mem[{set_i, word_i}] <= wdata_i;
    end

    assign rd_way[w] = mem[{set_i, word_i}];
  end

  assign rdata_o = rd_way[way_i];

endmodule

// File: rtl/dc_miss_seq.sv
module dc_miss_seq
  import dcache_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SETS       = 128,
  parameter int unsigned LINE_WORDS = 8,
  localparam int unsigned BYTE_W = $clog2(DATA_W / 8),
  localparam int unsigned WORD_W = $clog2(LINE_WORDS),
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned OFF_W  = WORD_W + BYTE_W,
  localparam int unsigned TAG_W  = ADDR_W - SET_W - OFF_W,
  localparam int unsigned WA_W   = ADDR_W - BYTE_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic                        req_write_i,
  input  logic                        req_wthru_i,
  input  logic [WA_W-1:0]             req_waddr_i,
  input  logic [DATA_W-1:0]           req_wdata_i,
  output logic                        rsp_valid_o,
  input  logic                        rsp_ready_i,
  output logic [DATA_W-1:0]           rsp_rdata_o,
  output logic                        mwr_valid_o,
  input  logic                        mwr_ready_i,
  output logic [ADDR_W-1:0]           mwr_addr_o,
  output logic [DATA_W-1:0]           mwr_data_o,
  output logic                        freq_valid_o,
  input  logic                        freq_ready_i,
  output logic [ADDR_W-1:0]           freq_addr_o,
  input  logic                        fdat_valid_i,
  output logic                        fdat_ready_o,
  input  logic [DATA_W-1:0]           fdat_data_i,
  // tag store side
  output logic [SET_W-1:0]            lk_set_o,
  output logic [TAG_W-1:0]            lk_tag_o,
  input  logic [NWAYS-1:0]            hit_i,
  input  logic [NWAYS-1:0][1:0]       way_st_i,
  input  logic [NWAYS-1:0][TAG_W-1:0] way_tag_i,
  input  logic                        lru_i,
  output logic                        st_we_o,
  output logic                        st_way_o,
  output line_st_e                    st_val_o,
  output logic                        tag_we_o,
  output logic                        lru_we_o,
  output logic                        lru_val_o,
  // data store side
  output logic                        d_way_o,
  output logic [WORD_W-1:0]           d_word_o,
  output logic                        d_we_o,
  output logic [DATA_W-1:0]           d_wdata_o,
  input  logic [DATA_W-1:0]           d_rdata_i
);

  localparam logic [WORD_W-1:0] LAST_W = WORD_W'(LINE_WORDS - 1);

  seq_st_e           st;
  logic [WORD_W-1:0] cnt;
  logic [WA_W-1:0]   r_wa;
  logic              r_write, r_wthru, r_vway;
  logic [DATA_W-1:0] r_wdata, rsp_q;

  logic              hit_any, hit_way, vic_c, last_beat;
  logic [SET_W-1:0]  cur_set;
  logic [TAG_W-1:0]  cur_tag;
  logic [WORD_W-1:0] cur_word;

  assign cur_word = r_wa[WORD_W-1:0];
  assign cur_set  = r_wa[WORD_W +: SET_W];
  assign cur_tag  = r_wa[WORD_W + SET_W +: TAG_W];
  assign hit_any  = |hit_i;
  assign hit_way  = hit_i[1];
  assign last_beat = (cnt == LAST_W);

  // Invalid way first (way 0 preferred), else the replacement bit
  always_comb begin
    if (way_st_i[0] == LS_INV)      vic_c = 1'b0;
    else if (way_st_i[1] == LS_INV) vic_c = 1'b1;
    else                            vic_c = lru_i;
  end

  assign lk_set_o = cur_set;
  assign lk_tag_o = cur_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      cnt     <= '0;
      r_wa    <= '0;
      r_write <= 1'b0;
      r_wthru <= 1'b0;
      r_wdata <= '0;
      r_vway  <= 1'b0;
      rsp_q   <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (req_valid_i) begin
          r_wa    <= req_waddr_i;
          r_write <= req_write_i;
          r_wthru <= req_wthru_i;
          r_wdata <= req_wdata_i;
          st      <= SQ_LOOK;
        end
        SQ_LOOK: begin
          if (hit_any) begin
            if (!r_write) rsp_q <= d_rdata_i;
            st <= (r_write && r_wthru) ? SQ_WTWR : SQ_RESP;
          end else if (r_write && r_wthru) begin
            st <= SQ_WTWR;
          end else begin
            r_vway <= vic_c;
            cnt    <= '0;
            st     <= (way_st_i[vic_c] == LS_MOD) ? SQ_EVICT : SQ_FREQ;
          end
        end
        SQ_WTWR: if (mwr_ready_i) st <= SQ_RESP;
        SQ_EVICT: if (mwr_ready_i) begin
          cnt <= cnt + 1'b1;
          if (last_beat) st <= SQ_FREQ;
        end
        SQ_FREQ: if (freq_ready_i) begin
          cnt <= '0;
          st  <= SQ_FILL;
        end
        SQ_FILL: if (fdat_valid_i) begin
          cnt <= cnt + 1'b1;
          if (last_beat) st <= SQ_LOOK;
        end
        SQ_RESP: if (rsp_ready_i) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    st_we_o   = 1'b0;
    st_way_o  = r_vway;
    st_val_o  = LS_INV;
    tag_we_o  = 1'b0;
    lru_we_o  = 1'b0;
    lru_val_o = 1'b0;
    d_way_o   = r_vway;
    d_word_o  = cnt;
    d_we_o    = 1'b0;
    d_wdata_o = r_wdata;
    unique case (st)
      SQ_LOOK: begin
        d_way_o  = hit_way;
        d_word_o = cur_word;
        if (hit_any) begin
          lru_we_o  = 1'b1;
          lru_val_o = ~hit_way;
          d_we_o    = r_write;
          if (r_write && !r_wthru) begin
            st_we_o  = 1'b1;
            st_way_o = hit_way;
            st_val_o = LS_MOD;
          end
        end
      end
      SQ_EVICT: begin
        if (mwr_ready_i && last_beat) st_we_o = 1'b1;
      end
      SQ_FILL: begin
        d_we_o    = fdat_valid_i;
        d_wdata_o = fdat_data_i;
        if (fdat_valid_i && last_beat) begin
          st_we_o   = 1'b1;
          st_val_o  = LS_EXC;
          tag_we_o  = 1'b1;
          lru_we_o  = 1'b1;
          lru_val_o = ~r_vway;
        end
      end
      default: ;
    endcase
  end

  assign req_ready_o  = (st == SQ_IDLE);
  assign rsp_valid_o  = (st == SQ_RESP);
  assign rsp_rdata_o  = rsp_q;
  assign fdat_ready_o = (st == SQ_FILL);
  assign freq_valid_o = (st == SQ_FREQ);
  assign freq_addr_o  = {cur_tag, cur_set, {OFF_W{1'b0}}};
  assign mwr_valid_o  = (st == SQ_WTWR) || (st == SQ_EVICT);

  always_comb begin
    if (st == SQ_EVICT) begin
      mwr_addr_o = {way_tag_i[r_vway], cur_set, cnt, {BYTE_W{1'b0}}};
      mwr_data_o = d_rdata_i;
    end else begin
      mwr_addr_o = {r_wa, {BYTE_W{1'b0}}};
      mwr_data_o = r_wdata;
    end
  end

  // R9
  evict_before_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freq_valid_o) |-> (way_st_i[r_vway] != LS_MOD));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_rdata_o)));

  // R11
  mwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr_valid_o && !mwr_ready_i) |=> (mwr_valid_o && $stable(mwr_addr_o) && $stable(mwr_data_o)));

  // R11
  freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_valid_o && !freq_ready_i) |=> (freq_valid_o && $stable(freq_addr_o)));

  // R8
  wt_miss_noalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_LOOK && !hit_any && r_write && r_wthru) |=> (mwr_valid_o && !freq_valid_o));

endmodule

// File: rtl/dc_mei_cache.sv
module dc_mei_cache
  import dcache_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SETS       = 128,
  parameter int unsigned LINE_WORDS = 8,
  localparam int unsigned BYTE_W = $clog2(DATA_W / 8),
  localparam int unsigned WORD_W = $clog2(LINE_WORDS),
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned TAG_W  = ADDR_W - SET_W - WORD_W - BYTE_W,
  localparam int unsigned WA_W   = ADDR_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wthru,
  input  logic [WA_W-1:0]   req_waddr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mwr_valid,
  input  logic              mwr_ready,
  output logic [ADDR_W-1:0] mwr_addr,
  output logic [DATA_W-1:0] mwr_data,
  output logic              freq_valid,
  input  logic              freq_ready,
  output logic [ADDR_W-1:0] freq_addr,
  input  logic              fdat_valid,
  output logic              fdat_ready,
  input  logic [DATA_W-1:0] fdat_data
);

  logic [SET_W-1:0]            lk_set;
  logic [TAG_W-1:0]            lk_tag;
  logic [NWAYS-1:0]            hit;
  logic [NWAYS-1:0][1:0]       way_st;
  logic [NWAYS-1:0][TAG_W-1:0] way_tag;
  logic                        lru, st_we, st_way, tag_we, lru_we, lru_val;
  line_st_e                    st_val;
  logic                        d_way, d_we;
  logic [WORD_W-1:0]           d_word;
  logic [DATA_W-1:0]           d_wdata, d_rdata;

  dc_miss_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .LINE_WORDS(LINE_WORDS)
  ) u_seq (
    .clk, .rst_n,
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_wthru_i(req_wthru), .req_waddr_i(req_waddr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .mwr_valid_o(mwr_valid), .mwr_ready_i(mwr_ready), .mwr_addr_o(mwr_addr), .mwr_data_o(mwr_data),
    .freq_valid_o(freq_valid), .freq_ready_i(freq_ready), .freq_addr_o(freq_addr),
    .fdat_valid_i(fdat_valid), .fdat_ready_o(fdat_ready), .fdat_data_i(fdat_data),
    .lk_set_o(lk_set), .lk_tag_o(lk_tag), .hit_i(hit), .way_st_i(way_st),
    .way_tag_i(way_tag), .lru_i(lru), .st_we_o(st_we), .st_way_o(st_way),
    .st_val_o(st_val), .tag_we_o(tag_we), .lru_we_o(lru_we), .lru_val_o(lru_val),
    .d_way_o(d_way), .d_word_o(d_word), .d_we_o(d_we), .d_wdata_o(d_wdata),
    .d_rdata_i(d_rdata)
  );

  dc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n,
    .lk_set_i(lk_set), .lk_tag_i(lk_tag), .hit_o(hit), .way_st_o(way_st),
    .way_tag_o(way_tag), .lru_o(lru), .st_we_i(st_we), .st_way_i(st_way),
    .st_val_i(st_val), .tag_we_i(tag_we), .lru_we_i(lru_we), .lru_val_i(lru_val)
  );

  dc_data_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk, .way_i(d_way), .set_i(lk_set), .word_i(d_word), .we_i(d_we),
    .wdata_i(d_wdata), .rdata_o(d_rdata)
  );

endmodule

// File: tb/dc_mei_cache_tb_top.sv
module dc_mei_cache_tb_top;

  localparam logic [1:0] OP_LD = 2'd0;
  localparam logic [1:0] OP_WB = 2'd1;
  localparam logic [1:0] OP_WT = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [3:0]  nfill;
    logic [3:0]  nwr;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{OP_LD, 32'h0000_0024, 32'h0, 32'hC0DE_0024, 4'd1, 4'd0, 4'd4},  // R4 cold miss, way 0
    '{OP_LD, 32'h0000_0028, 32'h0, 32'hC0DE_0028, 4'd0, 4'd0, 4'd3},  // R3
    '{OP_WB, 32'h0000_0024, 32'h1111_1111, 32'h0, 4'd0, 4'd0, 4'd6},  // R6
    '{OP_LD, 32'h0000_0024, 32'h0, 32'h1111_1111, 4'd0, 4'd0, 4'd6},  // R6
    '{OP_LD, 32'h0000_1020, 32'h0, 32'hC0DE_1020, 4'd1, 4'd0, 4'd5},  // R5 empty way 1
    '{OP_LD, 32'h0000_0020, 32'h0, 32'hC0DE_0020, 4'd0, 4'd0, 4'd3},  // R3
    '{OP_LD, 32'h0000_2020, 32'h0, 32'hC0DE_2020, 4'd1, 4'd0, 4'd5},  // R5 evicts way 1
    '{OP_LD, 32'h0000_1020, 32'h0, 32'hC0DE_1020, 4'd1, 4'd8, 4'd9},  // R9 modified victim
    '{OP_WT, 32'h0000_2024, 32'h2222_2222, 32'h0, 4'd0, 4'd1, 4'd7},  // R7
    '{OP_LD, 32'h0000_0024, 32'h0, 32'h1111_1111, 4'd1, 4'd0, 4'd9},  // R9 written-back data
    '{OP_LD, 32'h0000_2024, 32'h0, 32'h2222_2222, 4'd0, 4'd0, 4'd7},  // R7
    '{OP_LD, 32'h0000_0020, 32'h0, 32'hC0DE_0020, 4'd0, 4'd0, 4'd3},  // R3
    '{OP_LD, 32'h0000_3020, 32'h0, 32'hC0DE_3020, 4'd1, 4'd0, 4'd7},  // R7 line still clean
    '{OP_WT, 32'h0000_4040, 32'h3333_3333, 32'h0, 4'd0, 4'd1, 4'd8},  // R8
    '{OP_LD, 32'h0000_4040, 32'h0, 32'h3333_3333, 4'd1, 4'd0, 4'd8},  // R8
    '{OP_WB, 32'h0000_5048, 32'h4444_4444, 32'h0, 4'd1, 4'd0, 4'd12}, // R12
    '{OP_LD, 32'h0000_5048, 32'h0, 32'h4444_4444, 4'd0, 4'd0, 4'd12}, // R12
    '{OP_LD, 32'h0000_504C, 32'h0, 32'hC0DE_504C, 4'd0, 4'd0, 4'd12}, // R12
    '{OP_LD, 32'hFFFF_FFFC, 32'h0, 32'h3F21_FFFC, 4'd1, 4'd0, 4'd2},  // R2 set 127
    '{OP_LD, 32'h0000_0FFC, 32'h0, 32'hC0DE_0FFC, 4'd1, 4'd0, 4'd2},  // R2
    '{OP_LD, 32'hFFFF_FFE0, 32'h0, 32'h3F21_FFE0, 4'd0, 4'd0, 4'd2},  // R2
    '{OP_LD, 32'h0000_4044, 32'h0, 32'hC0DE_4044, 4'd0, 4'd0, 4'd3}   // R3
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_wthru;
  logic [29:0] req_waddr;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_rdata;
  logic        mwr_valid, mwr_ready;
  logic [31:0] mwr_addr, mwr_data;
  logic        freq_valid, freq_ready;
  logic [31:0] freq_addr;
  logic        fdat_valid, fdat_ready;
  logic [31:0] fdat_data;

  dc_mei_cache dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_wthru, .req_waddr,
    .req_wdata, .rsp_valid, .rsp_ready, .rsp_rdata, .mwr_valid, .mwr_ready,
    .mwr_addr, .mwr_data, .freq_valid, .freq_ready, .freq_addr, .fdat_valid,
    .fdat_ready, .fdat_data
  );

  int n_chk = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  int fill_cnt = 0;
  int exp_wr_now = 0;
  logic [31:0] cur_addr = '0;
  logic [31:0] cur_wdata = '0;
  logic [31:0] bmem [logic [31:0]];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (bmem.exists(a)) return bmem[a];
    return pat(a);
  endfunction

  task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Memory and fill engine models with pseudo-random back-pressure
  logic        fill_pend = 1'b0;
  logic [31:0] fill_base = '0;
  int          beat = 0;
  logic [7:0]  lf = 8'h5B;

  initial begin
    mwr_ready = 1'b0; freq_ready = 1'b0; fdat_valid = 1'b0; fdat_data = '0;
    forever begin
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      mwr_ready  = lf[0] | lf[2];
      freq_ready = lf[1] | lf[3];
      if (mwr_valid && mwr_ready) begin
        if (exp_wr_now == 8)
          chk(9, "evict beat offset", {27'd0, mwr_addr[4:0]}, 32'(wr_cnt * 4)); // R9
        if (exp_wr_now == 1) begin
          chk(7, "memory write address", mwr_addr, {cur_addr[31:2], 2'b00}); // R7 R8
          chk(7, "memory write data", mwr_data, cur_wdata);
        end
        bmem[mwr_addr] = mwr_data;
        wr_cnt++;
      end
      if (fill_pend) begin
        fdat_valid = lf[4] | lf[6];
        fdat_data  = mem_rd(fill_base + 32'(beat * 4));
        if (fdat_valid && fdat_ready) begin
          beat++;
          if (beat == 8) fill_pend = 1'b0;
        end
      end else begin
        fdat_valid = 1'b0;
      end
      if (freq_valid && freq_ready) begin
        chk(9, "writes done before fill", 32'(wr_cnt), 32'(exp_wr_now)); // R9
        chk(2, "fill line address", freq_addr, {cur_addr[31:5], 5'd0});   // R2
        fill_cnt++;
        fill_pend = 1'b1;
        fill_base = freq_addr;
        beat = 0;
      end
    end
  end

  task automatic run_txn(input logic [1:0] op, input logic [31:0] a, input logic [31:0] wd,
                         input int hold, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = (op != OP_LD);
    req_wthru = (op == OP_WT);
    req_waddr = a[31:2];
    req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(10, "ready low while busy", {31'd0, req_ready}, 32'd0); // R10
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(11, "response held", {31'd0, rsp_valid}, 32'd1);  // R11
      chk(11, "response stable", rsp_rdata, rd);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic do_vec(input vec_t v, input int hold);
    logic [31:0] rd;
    cur_addr = v.addr;
    cur_wdata = v.wd;
    exp_wr_now = int'(v.nwr);
    wr_cnt = 0;
    fill_cnt = 0;
    run_txn(v.op, v.addr, v.wd, hold, rd);
    if (v.op == OP_LD) chk(int'(v.rq), "load data", rd, v.exp);
    chk(int'(v.rq), "fill count", 32'(fill_cnt), {28'd0, v.nfill});
    chk(int'(v.rq), "memory write count", 32'(wr_cnt), {28'd0, v.nwr});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_wthru = 1'b0;
    req_waddr = '0; req_wdata = '0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    chk(1, "req_ready after reset", {31'd0, req_ready}, 32'd1);
    chk(1, "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk(1, "mwr_valid after reset", {31'd0, mwr_valid}, 32'd0);
    chk(1, "freq_valid after reset", {31'd0, freq_valid}, 32'd0);

    for (int i = 0; i < NV; i++) do_vec(VECS[i], i % 3);

    // R1: reset in mid-run invalidates every line
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_vec('{OP_LD, 32'h0000_0024, 32'h0, 32'h1111_1111, 4'd1, 4'd0, 4'd1}, 0);
    do_vec('{OP_LD, 32'h0000_2024, 32'h0, 32'h2222_2222, 4'd1, 4'd0, 4'd1}, 0);
    // R11: long response back-pressure
    do_vec('{OP_LD, 32'h0000_0028, 32'h0, 32'hC0DE_0028, 4'd0, 4'd0, 4'd11}, 6);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule